// File: doc/BRIEF.md
# ADC Conversion Start Timing Controller

This block decides when an analog-to-digital converter begins a conversion. It issues single-cycle start pulses from three sources:

- a software write to a control strobe carrying a start bit;
- a programmable periodic timer whose period is a divisor counted in base clocks;
- a selected edge on a raw digital input.

The digital input can play one of two roles. As a trigger, it launches periodic acquisition after software has armed the block. As a per-sample start, every selected edge produces one conversion.

What a start-bit write does depends on the divisor and the trigger enable:

- With a zero divisor, the write fires exactly one conversion.
- With a nonzero divisor and the trigger disabled, the write fires at once and then repeats every divisor clocks.
- With a nonzero divisor and the trigger enabled, the write only arms the block and waits for the edge.

A write with the start bit cleared stops everything. Accepted input edges set a sticky interrupt flag, which software clears by writing one.

Top module: `adc_start_ctrl`

## Requirements
- R1: While reset is held low, start_pulse, armed, running and irq are all 0 at the next clock edge.
- R2: With rate_div equal to 0, a write with ctl_go=1 gives start_pulse=1 for exactly the one cycle after the write edge. After that write, running and armed stay 0.
- R3: With rate_div=N (N at least 1) and trig_en=0, a write with ctl_go=1 gives a pulse in the cycle after the write edge and sets running. Pulses then repeat exactly N clocks apart, so N=1 pulses on every clock.
- R4: With rate_div nonzero and trig_en=1, a write with ctl_go=1 sets armed and issues no pulse. The first selected edge on din then gives one pulse, clears armed, sets running and starts periodic pulses N clocks apart.
- R5: A write with ctl_go=0 clears armed and running. No periodic pulse follows it.
- R6: With xstart_en=1, each selected edge on din gives exactly one single-cycle pulse. A din change captured at clock edge k shows start_pulse after clock edge k+2 (two synchronizer flops plus the edge register).
- R7: edge_pol=0 selects the rising edge of din and edge_pol=1 selects the falling edge. The opposite transition produces no pulse and no interrupt.
- R8: An edge on din while the block is not armed and xstart_en=0 produces no pulse and leaves irq at 0.
- R9: irq is set by an accepted trigger edge or external-start edge. It stays set until a cycle with irq_clr=1 and no new accepted edge.
- R10: If rate_div becomes 0 while running, running clears at the next clock edge and no further periodic pulses appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; periodic rate is its frequency divided by rate_div |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | One-cycle control write strobe |
| ctl_go | input | 1 | Start bit carried by the control write |
| rate_div | input | DIV_W | Period divisor in clocks; 0 selects single-shot |
| trig_en | input | 1 | Digital input acts as trigger for periodic acquisition |
| xstart_en | input | 1 | Digital input edges each start one conversion |
| edge_pol | input | 1 | 0 = rising edge, 1 = falling edge |
| din | input | 1 | Raw asynchronous digital input |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| start_pulse | output | 1 | Single-cycle conversion start |
| armed | output | 1 | Waiting for trigger edge |
| running | output | 1 | Periodic starts active |
| irq | output | 1 | Sticky interrupt request |

## Verification
The periodic sweep covers divisors 1 through 6 and compares every cycle against the pattern that puts a pulse only when the cycle index is a multiple of the divisor. An off-by-one in the reload would stretch or shrink each period by one clock and break that pattern. Trigger and external-start runs use both polarities and check the exact three-edge latency through the synchronizer. A wrong polarity decode would fire on the trailing transition instead of the leading one. An edge leaking through while the block is not armed would show up as a stray pulse or a set interrupt flag. Stop writes and a divisor forced to zero while running must both end the pulse train at once; a design that finishes its current period first would produce one extra pulse.

// File: rtl/adc_start_pkg.sv
// Shared types for the ADC start timing controller.
package adc_start_pkg;
    // Acquisition state of the start controller.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } run_state_t;
endpackage

// File: rtl/din_edge_sync.sv
// Synchronizes a raw asynchronous input through STAGES flops and flags the
// selected edge for one cycle. Assumes pol is quasi-static; a change of pol
// may itself be seen as an edge, so callers disable consumers while changing it.
module din_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic pol,
    output logic edge_hit
);
    logic [STAGES-1:0] sync_q;
    logic              lvl;
    logic              lvl_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single-stage capture of the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= din;
            end
        end else begin : g_chain
            // Shift chain that resolves metastability on the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], din};
            end
        end
    endgenerate

    // Normalize polarity so the selected edge is always a rise of lvl.
    assign lvl = sync_q[STAGES-1] ^ pol;

    // Remember last normalized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign edge_hit = lvl & ~lvl_q;
endmodule

// File: rtl/period_timer.sv
// Down-counter that ticks once every div clocks while run is high.
// load restarts the period: the next tick falls exactly div clocks later.
// Assumes div is nonzero whenever run or load is asserted.
module period_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] reload;

    assign reload = div - W'(1);

    // Count down, reloading on load or on reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= reload;
        else if (run) begin
            if (cnt_q == '0)   cnt_q <= reload;
            else               cnt_q <= cnt_q - W'(1);
        end
    end

    assign tick = run & ~load & (cnt_q == '0);
endmodule

// File: rtl/adc_start_ctrl.sv
// ADC conversion start timing controller. Combines software start writes,
// a periodic divider and a synchronized digital input edge into a registered
// single-cycle start pulse. A control write takes priority over a trigger
// edge and a periodic tick in the same cycle; external-start edges are
// independent and OR into the pulse. Assumes ctl_wr is a one-cycle strobe.
module adc_start_ctrl
    import adc_start_pkg::*;
#(
    parameter int DIV_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_go,
    input  logic [DIV_W-1:0] rate_div,
    input  logic             trig_en,
    input  logic             xstart_en,
    input  logic             edge_pol,
    input  logic             din,
    input  logic             irq_clr,
    output logic             start_pulse,
    output logic             armed,
    output logic             running,
    output logic             irq
);
    run_state_t state_q, state_d;
    logic       pulse_q, pulse_d;
    logic       irq_q, irq_d;
    logic       edge_hit;
    logic       tick;
    logic       div_zero, go_wr, stop_wr;
    logic       trig_hit, xs_hit, load;

    din_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .pol      (edge_pol),
        .edge_hit (edge_hit)
    );

    period_timer #(.W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .run   (state_q == ST_RUN),
        .div   (rate_div),
        .tick  (tick)
    );

    // Decode the control write and qualify input edges.
    always_comb begin
        div_zero = (rate_div == '0);
        go_wr    = ctl_wr & ctl_go;
        stop_wr  = ctl_wr & ~ctl_go;
        trig_hit = ~ctl_wr & trig_en & edge_hit & (state_q == ST_ARMED);
        xs_hit   = xstart_en & edge_hit;
        load     = (go_wr & ~div_zero & ~trig_en) | trig_hit;
    end

    // Next acquisition state.
    always_comb begin
        state_d = state_q;
        if (stop_wr) begin
            state_d = ST_IDLE;
        end else if (go_wr) begin
            if (div_zero)     state_d = ST_IDLE;
            else if (trig_en) state_d = ST_ARMED;
            else              state_d = ST_RUN;
        end else begin
            case (state_q)
                ST_ARMED: if (trig_hit) state_d = div_zero ? ST_IDLE : ST_RUN;
                ST_RUN:   if (div_zero) state_d = ST_IDLE;
                default:  state_d = state_q;
            endcase
        end
    end

    // Start pulse sources and sticky interrupt update.
    always_comb begin
        pulse_d = (go_wr & ~(trig_en & ~div_zero))
                | trig_hit
                | (~ctl_wr & (state_q == ST_RUN) & ~div_zero & tick)
                | xs_hit;
        if (trig_hit | xs_hit) irq_d = 1'b1;
        else if (irq_clr)      irq_d = 1'b0;
        else                   irq_d = irq_q;
    end

    // State, pulse and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pulse_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= pulse_d;
            irq_q   <= irq_d;
        end
    end

    assign start_pulse = pulse_q;
    assign armed       = (state_q == ST_ARMED);
    assign running     = (state_q == ST_RUN);
    assign irq         = irq_q;
endmodule

// File: rtl/adc_start_chk.sv
// Property checker for adc_start_ctrl, attached by bind below.
module adc_start_chk #(
    parameter int DIV_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             ctl_go,
    input logic [DIV_W-1:0] rate_div,
    input logic             trig_en,
    input logic             xstart_en,
    input logic             irq_clr,
    input logic             start_pulse,
    input logic             armed,
    input logic             running,
    input logic             irq
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!start_pulse && !armed && !running && !irq));

    assert_single_shot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_go && rate_div == '0) |=> (start_pulse && !running && !armed));

    assert_free_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_go && rate_div != '0 && !trig_en) |=> (start_pulse && running));

    assert_arm_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_go && rate_div != '0 && trig_en && !xstart_en) |=> (armed && !start_pulse));

    assert_state_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && running));

    assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_go) |=> (!running && !armed));

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    assert_zero_div_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && rate_div == '0 && !ctl_wr) |=> !running);
endmodule

bind adc_start_ctrl adc_start_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_adc_start_ctrl.sv
// Self-checking bench: sweeps divisors, both polarities and all three modes.
module sim_adc_start_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_go = 1'b0;
    logic [31:0] rate_div = '0;
    logic        trig_en = 1'b0, xstart_en = 1'b0, edge_pol = 1'b0;
    logic        din = 1'b0, irq_clr = 1'b0;
    logic        start_pulse, armed, running, irq;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    adc_start_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_go(ctl_go),
        .rate_div(rate_div), .trig_en(trig_en), .xstart_en(xstart_en),
        .edge_pol(edge_pol), .din(din), .irq_clr(irq_clr),
        .start_pulse(start_pulse), .armed(armed), .running(running), .irq(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic go);
        ctl_wr = 1'b1; ctl_go = go;
        tick();
        ctl_wr = 1'b0; ctl_go = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        chk("R1 pulse", start_pulse, 1'b0);
        chk("R1 armed", armed, 1'b0);
        chk("R1 running", running, 1'b0);
        chk("R1 irq", irq, 1'b0);
        rst_n = 1'b1;
        tick();

        // R2: single shot with zero divisor
        rate_div = 0;
        wr(1'b1);
        chk("R2 pulse", start_pulse, 1'b1);
        chk("R2 running", running, 1'b0);
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R2 no repeat", start_pulse, 1'b0);
        end

        // R3 / R5: periodic sweep over divisors, then stop
        for (int n = 1; n <= 6; n++) begin
            rate_div = n;
            wr(1'b1);
            for (int i = 0; i <= 3 * n; i++) begin
                chk("R3 period", start_pulse, (i % n) == 0);
                chk("R3 running", running, 1'b1);
                tick();
            end
            wr(1'b0);
            chk("R5 running", running, 1'b0);
            chk("R5 pulse", start_pulse, 1'b0);
            for (int i = 0; i < 2 * n + 2; i++) begin
                tick();
                chk("R5 quiet", start_pulse, 1'b0);
            end
        end

        // R10: divisor forced to zero while running
        rate_div = 3;
        wr(1'b1);
        tick();
        rate_div = 0;
        tick();
        chk("R10 running", running, 1'b0);
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R10 quiet", start_pulse, 1'b0);
        end

        // R4 / R7 / R8 / R9: trigger mode, both polarities, several divisors
        for (int p = 0; p <= 1; p++) begin
            for (int n = 2; n <= 4; n++) begin
                trig_en = 1'b0; xstart_en = 1'b0;
                edge_pol = p[0]; din = p[0]; rate_div = n;
                repeat (5) tick();
                clear_irq();
                trig_en = 1'b1;
                din = ~p[0];
                for (int i = 0; i < 5; i++) begin
                    tick();
                    chk("R8 unarmed edge", start_pulse, 1'b0);
                end
                chk("R8 irq", irq, 1'b0);
                din = p[0];
                repeat (5) tick();
                wr(1'b1);
                chk("R4 armed", armed, 1'b1);
                chk("R4 not running", running, 1'b0);
                chk("R4 no pulse", start_pulse, 1'b0);
                for (int i = 0; i < 4; i++) begin
                    tick();
                    chk("R4 waiting", start_pulse, 1'b0);
                end
                din = ~p[0];
                tick(); chk("R4 latency1", start_pulse, 1'b0);
                tick(); chk("R4 latency2", start_pulse, 1'b0);
                tick(); chk("R4 trig pulse", start_pulse, 1'b1);
                chk("R4 running", running, 1'b1);
                chk("R4 disarmed", armed, 1'b0);
                chk("R9 irq set", irq, 1'b1);
                din = p[0];
                for (int i = 1; i <= 2 * n; i++) begin
                    tick();
                    chk("R4 period", start_pulse, (i % n) == 0);
                end
                chk("R7 trailing edge no irq change", irq, 1'b1);
                wr(1'b0);
                chk("R5 stop", running, 1'b0);
                for (int i = 0; i < 2 * n + 4; i++) begin
                    tick();
                    chk("R5 quiet", start_pulse, 1'b0);
                end
                chk("R9 sticky", irq, 1'b1);
                clear_irq();
                chk("R9 cleared", irq, 1'b0);
                din = ~p[0];
                for (int i = 0; i < 4; i++) begin
                    tick();
                    chk("R8 after stop", start_pulse, 1'b0);
                end
                chk("R8 irq after stop", irq, 1'b0);
                din = p[0];
                repeat (4) tick();
            end
        end
        trig_en = 1'b0;

        // R6 / R7 / R9: external start, both polarities
        rate_div = 0;
        for (int p = 0; p <= 1; p++) begin
            xstart_en = 1'b0;
            edge_pol = p[0]; din = p[0];
            repeat (5) tick();
            clear_irq();
            xstart_en = 1'b1;
            for (int k = 0; k < 4; k++) begin
                din = ~p[0];
                tick(); chk("R6 latency1", start_pulse, 1'b0);
                tick(); chk("R6 latency2", start_pulse, 1'b0);
                tick(); chk("R6 pulse", start_pulse, 1'b1);
                chk("R9 xstart irq", irq, 1'b1);
                tick(); chk("R6 single cycle", start_pulse, 1'b0);
                clear_irq();
                chk("R9 clear", irq, 1'b0);
                din = p[0];
                for (int i = 0; i < 4; i++) begin
                    tick();
                    chk("R7 opposite edge", start_pulse, 1'b0);
                end
                chk("R7 opposite edge irq", irq, 1'b0);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule